// File: doc/BRIEF.md
# Page-Write Exception Entry Sequencer

This block performs the control-state side of taking a page-write exception. When a request arrives and the current status word does not mask it, the block captures a snapshot of the machine in one clock edge. The snapshot holds a restart address, the status word and the general stack-pointer value. It also records a fixed event code, produces the new status word for the core to load, and issues a one-cycle fetch redirect to the handler at a fixed offset from the vector base.

The restart address is normally the PC of the faulting instruction. When the fault came from a delay slot, the address of the branch that owns the slot is kept instead, so that the handler returns to the branch. The core owns the live status register: it feeds the current value in on `sr_in` and loads `sr_next` whenever `sr_load` pulses. A return strobe makes the block hand the saved status word back through the same load path, which drops the masking bit again.

Top module: `exc_entry_seq`

## Requirements
- R1: In the cycle after reset, `redirect` and `sr_load` are 0, and `saved_pc`, `saved_sr`, `saved_sp`, `event_code`, `sr_next` and `fetch_target` are all 0.
- R2: A request is accepted when `exc_req` is 1 and bit 28 of `sr_in` (the mask bit) is 0. After the clock edge that accepts it, `event_code` reads 0x0000_0080.
- R3: After an accepted request, `saved_pc` equals `fault_pc` when `in_slot` was 0. It equals `branch_pc` when `in_slot` was 1.
- R4: After an accepted request, `saved_sr` equals the `sr_in` value and `saved_sp` equals the `sp_in` value sampled at acceptance.
- R5: After an accepted request, `sr_load` is 1 for one cycle. `sr_next` then equals the accepted `sr_in` with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (mask) set to 1, and every other bit unchanged.
- R6: After an accepted request, `redirect` is 1 for one cycle. `fetch_target` equals `vbr_in` + 0x100, modulo 2^32.
- R7: A request while bit 28 of `sr_in` is 1 is ignored. The next cycle shows `redirect` = 0, `sr_load` = 0, and no change to `saved_pc`, `saved_sr`, `saved_sp` or `event_code`.
- R8: A `ret_strobe` without an accepted request gives, one cycle later, `sr_load` = 1 and `sr_next` equal to the `saved_sr` held before that edge. `redirect` stays 0 and the saved registers do not change.
- R9: When a request is accepted in the same cycle as `ret_strobe`, the entry takes effect and the return is dropped.
- R10: In a cycle with neither an accepted request nor a return strobe, `redirect` and `sr_load` fall to 0 and the saved registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Page-write exception request |
| fault_pc | input | 32 | PC of the faulting instruction |
| in_slot | input | 1 | Fault came from a delay slot |
| branch_pc | input | 32 | PC of the delayed branch owning the slot |
| sr_in | input | 32 | Current status word from the core |
| sp_in | input | 32 | Current general stack-pointer value |
| vbr_in | input | 32 | Vector base address |
| ret_strobe | input | 1 | Return-from-exception strobe |
| saved_pc | output | 32 | Saved restart address |
| saved_sr | output | 32 | Saved status word |
| saved_sp | output | 32 | Saved stack-pointer value |
| event_code | output | 32 | Exception event code |
| sr_next | output | 32 | Status word for the core to load |
| sr_load | output | 1 | One-cycle load strobe for `sr_next` |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| fetch_target | output | 32 | Handler fetch address |

## Verification
The checker assumes that `sr_in` comes from the core and reflects the previous `sr_load` only when the core chooses to load it. Because of this, it decides acceptance purely from `exc_req` and bit 28 of `sr_in` in the same cycle, and does not assume the mask bit has already risen. The stimulus drives `sr_in` directly. It first presents each request with the mask bit clear, then a masked request and a return with the mask bit set, and finally a simultaneous request and return with the mask clear. Operands are only ever changed between edges.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN        = 32;
    localparam int SR_MD_BIT   = 30;
    localparam int SR_RB_BIT   = 29;
    localparam int SR_BL_BIT   = 28;

    typedef logic [XLEN-1:0] word_t;

    localparam word_t PAGE_WRITE_CODE = 32'h0000_0080;
    localparam word_t HANDLER_OFFSET  = 32'h0000_0100;

    // Machine state captured at exception entry.
    typedef struct packed {
        word_t pc;
        word_t sr;
        word_t sp;
    } snap_t;

    // Decision taken in one cycle.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } act_e;

    function automatic logic sr_masked(word_t s);
        return s[SR_BL_BIT];
    endfunction

    function automatic word_t sr_on_entry(word_t s);
        word_t r;
        r = s;
        r[SR_MD_BIT] = 1'b1;
        r[SR_RB_BIT] = 1'b1;
        r[SR_BL_BIT] = 1'b1;
        return r;
    endfunction

    function automatic word_t pick_restart(logic slot, word_t fpc, word_t bpc);
        return slot ? bpc : fpc;
    endfunction

endpackage

// File: rtl/exc_gate.sv
module exc_gate
    import exc_entry_pkg::*;
(
    input  logic  exc_req,
    input  logic  ret_strobe,
    input  word_t sr_in,
    output act_e  act
);
    always_comb begin
        if (exc_req && !sr_masked(sr_in))
            act = ACT_ENTER;
        else if (ret_strobe)
            act = ACT_RETURN;
        else
            act = ACT_IDLE;
    end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
    import exc_entry_pkg::*;
#(
    parameter word_t EVENT_CODE = PAGE_WRITE_CODE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  snap_t snap_d,
    output snap_t snap_q,
    output word_t code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            code_q <= '0;
        end else if (load) begin
            snap_q <= snap_d;
            code_q <= EVENT_CODE;
        end
    end
endmodule

// File: rtl/exc_flow_ctl.sv
module exc_flow_ctl
    import exc_entry_pkg::*;
#(
    parameter word_t VEC_OFFSET = HANDLER_OFFSET
) (
    input  logic  clk,
    input  logic  rst,
    input  act_e  act,
    input  word_t sr_in,
    input  word_t sr_saved,
    input  word_t vbr_in,
    output word_t sr_next,
    output logic  sr_load,
    output logic  redirect,
    output word_t fetch_target
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_next      <= '0;
            sr_load      <= 1'b0;
            redirect     <= 1'b0;
            fetch_target <= '0;
        end else begin
            unique case (act)
                ACT_ENTER: begin
                    sr_next      <= sr_on_entry(sr_in);
                    sr_load      <= 1'b1;
                    redirect     <= 1'b1;
                    fetch_target <= vbr_in + VEC_OFFSET;
                end
                ACT_RETURN: begin
                    sr_next  <= sr_saved;
                    sr_load  <= 1'b1;
                    redirect <= 1'b0;
                end
                default: begin
                    sr_load  <= 1'b0;
                    redirect <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] EVENT_CODE = PAGE_WRITE_CODE,
    parameter logic [31:0] VEC_OFFSET = HANDLER_OFFSET
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_req,
    input  logic [31:0] fault_pc,
    input  logic        in_slot,
    input  logic [31:0] branch_pc,
    input  logic [31:0] sr_in,
    input  logic [31:0] sp_in,
    input  logic [31:0] vbr_in,
    input  logic        ret_strobe,
    output logic [31:0] saved_pc,
    output logic [31:0] saved_sr,
    output logic [31:0] saved_sp,
    output logic [31:0] event_code,
    output logic [31:0] sr_next,
    output logic        sr_load,
    output logic        redirect,
    output logic [31:0] fetch_target
);
    act_e  act;
    snap_t snap_d;
    snap_t snap_q;

    exc_gate u_gate (
        .exc_req    (exc_req),
        .ret_strobe (ret_strobe),
        .sr_in      (sr_in),
        .act        (act)
    );

    always_comb begin
        snap_d.pc = pick_restart(in_slot, fault_pc, branch_pc);
        snap_d.sr = sr_in;
        snap_d.sp = sp_in;
    end

    exc_save_bank #(.EVENT_CODE(EVENT_CODE)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (act == ACT_ENTER),
        .snap_d (snap_d),
        .snap_q (snap_q),
        .code_q (event_code)
    );

    exc_flow_ctl #(.VEC_OFFSET(VEC_OFFSET)) u_flow (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .sr_in        (sr_in),
        .sr_saved     (snap_q.sr),
        .vbr_in       (vbr_in),
        .sr_next      (sr_next),
        .sr_load      (sr_load),
        .redirect     (redirect),
        .fetch_target (fetch_target)
    );

    assign saved_pc = snap_q.pc;
    assign saved_sr = snap_q.sr;
    assign saved_sp = snap_q.sp;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        exc_req,
    input logic [31:0] fault_pc,
    input logic        in_slot,
    input logic [31:0] branch_pc,
    input logic [31:0] sr_in,
    input logic [31:0] sp_in,
    input logic [31:0] vbr_in,
    input logic        ret_strobe,
    input logic [31:0] saved_pc,
    input logic [31:0] saved_sr,
    input logic [31:0] saved_sp,
    input logic [31:0] event_code,
    input logic [31:0] sr_next,
    input logic        sr_load,
    input logic        redirect,
    input logic [31:0] fetch_target
);
    logic acc;
    assign acc = exc_req && !sr_in[28];

    AST_ENTRY_CODE: assert property (@(posedge clk) disable iff (rst)
        acc |=> event_code == 32'h80); // R2
    AST_RESTART_PC: assert property (@(posedge clk) disable iff (rst)
        acc |=> saved_pc == ($past(in_slot) ? $past(branch_pc) : $past(fault_pc))); // R3
    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
        acc |=> (saved_sr == $past(sr_in)) && (saved_sp == $past(sp_in))); // R4
    AST_ENTRY_SR: assert property (@(posedge clk) disable iff (rst)
        acc |=> sr_load && (sr_next == ($past(sr_in) | 32'h7000_0000))); // R5
    AST_VECTOR: assert property (@(posedge clk) disable iff (rst)
        acc |=> redirect && (fetch_target == $past(vbr_in) + 32'h100)); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (exc_req && sr_in[28] && !ret_strobe) |=> !redirect && !sr_load && $stable(saved_pc) && $stable(event_code)); // R7
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !acc) |=> sr_load && !redirect && (sr_next == $past(saved_sr)) && $stable(saved_sr)); // R8
    AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && acc) |=> redirect); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc && !ret_strobe) |=> !redirect && !sr_load && $stable(saved_sr) && $stable(saved_sp)); // R10
endmodule

bind exc_entry_seq exc_entry_chk u_chk (.*);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req, in_slot, ret_strobe;
    logic [31:0] fault_pc, branch_pc, sr_in, sp_in, vbr_in;
    logic [31:0] saved_pc, saved_sr, saved_sp, event_code, sr_next, fetch_target;
    logic        sr_load, redirect;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    exc_entry_seq u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        exc_req = 0; ret_strobe = 0; in_slot = 0;
    endtask

    initial begin
        #150000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pcs [4];
        logic [31:0] vbrs [3];
        logic [31:0] srs [3];
        logic [31:0] exp_pc, exp_sr, exp_sp;
        pcs[0] = 32'h0000_0000; pcs[1] = 32'h8C00_1234;
        pcs[2] = 32'hFFFF_FFFE; pcs[3] = 32'h0040_0A02;
        vbrs[0] = 32'h0000_0000; vbrs[1] = 32'hA000_0000; vbrs[2] = 32'hFFFF_FF80;
        srs[0] = 32'h0000_0000; srs[1] = 32'h0000_00F3; srs[2] = 32'h8FFF_FFFF;
        idle_in();
        fault_pc = 0; branch_pc = 0; sr_in = 0; sp_in = 0; vbr_in = 0;
        rst = 1;
        @(negedge clk); step();
        rst = 0;
        step();
        chk("R1 redirect", {31'd0, redirect}, 0);
        chk("R1 sr_load", {31'd0, sr_load}, 0);
        chk("R1 saved_pc", saved_pc, 0);
        chk("R1 saved_sr", saved_sr, 0);
        chk("R1 saved_sp", saved_sp, 0);
        chk("R1 event_code", event_code, 0);
        chk("R1 sr_next", sr_next, 0);
        chk("R1 fetch_target", fetch_target, 0);

        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 2; s++)
                for (int v = 0; v < 3; v++) begin
                    // accepted entry
                    exc_req = 1; in_slot = s[0];
                    fault_pc = pcs[p]; branch_pc = pcs[p] - 32'd2;
                    sr_in = srs[v]; sp_in = pcs[p] ^ 32'h5A5A_0F0F; vbr_in = vbrs[v];
                    exp_pc = s[0] ? branch_pc : fault_pc;
                    exp_sr = srs[v]; exp_sp = sp_in;
                    step();
                    chk("R2 event_code", event_code, 32'h80);
                    chk("R3 saved_pc", saved_pc, exp_pc);
                    chk("R4 saved_sr", saved_sr, exp_sr);
                    chk("R4 saved_sp", saved_sp, exp_sp);
                    chk("R5 sr_load", {31'd0, sr_load}, 1);
                    chk("R5 sr_next", sr_next, exp_sr | 32'h7000_0000);
                    chk("R6 redirect", {31'd0, redirect}, 1);
                    chk("R6 fetch_target", fetch_target, vbrs[v] + 32'h100);
                    // masked request
                    exc_req = 1; in_slot = ~s[0];
                    fault_pc = 32'h1111_1110; branch_pc = 32'h2222_2220;
                    sr_in = srs[v] | 32'h7000_0000; sp_in = 32'h3333_3333;
                    vbr_in = 32'h4444_4444;
                    step();
                    chk("R7 redirect", {31'd0, redirect}, 0);
                    chk("R7 sr_load", {31'd0, sr_load}, 0);
                    chk("R7 saved_pc", saved_pc, exp_pc);
                    chk("R7 saved_sr", saved_sr, exp_sr);
                    chk("R7 saved_sp", saved_sp, exp_sp);
                    // return
                    exc_req = 0; ret_strobe = 1;
                    step();
                    chk("R8 sr_load", {31'd0, sr_load}, 1);
                    chk("R8 sr_next", sr_next, exp_sr);
                    chk("R8 redirect", {31'd0, redirect}, 0);
                    chk("R8 saved_pc", saved_pc, exp_pc);
                    // idle
                    idle_in();
                    step();
                    chk("R10 redirect", {31'd0, redirect}, 0);
                    chk("R10 sr_load", {31'd0, sr_load}, 0);
                    chk("R10 saved_sr", saved_sr, exp_sr);
                    chk("R10 saved_sp", saved_sp, exp_sp);
                end

        // simultaneous entry and return with mask clear
        exc_req = 1; ret_strobe = 1; in_slot = 0;
        fault_pc = 32'hCAFE_0010; sr_in = 32'h0000_0001; sp_in = 32'h0BAD_F00D;
        vbr_in = 32'h1000_0000;
        step();
        chk("R9 redirect", {31'd0, redirect}, 1);
        chk("R9 sr_next", sr_next, 32'h7000_0001);
        chk("R9 saved_pc", saved_pc, 32'hCAFE_0010);
        chk("R9 fetch_target", fetch_target, 32'h1000_0100);
        idle_in();
        step();
        chk("R10 redirect drop", {31'd0, redirect}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule